// File: doc/BRIEF.md
# Debounced Wake-Pin Event Controller

This block looks after three general-purpose wake pins. Each pin can be driven out or read in. When a pin is an input, its raw level passes through a two-flop synchroniser. A per-pin polarity bit then sets which level counts as asserted. After that, a debounce counter must see the new level hold steady for 31 timebase ticks before the level is accepted. The timebase is a 1 MHz tick that the block receives as an input, so 31 ticks is about 31 µs.

When the debounced level becomes asserted, the block sets a sticky per-pin status bit, which software clears by writing 1 to it. A single interrupt output, `smi`, is the OR of the status bits of pins that are inputs and have their interrupt enabled. When a pin is switched to output, its detection is masked and its debounce state follows the live level. Switching the pin back to input therefore cannot report a stale edge.

Software reaches the block through a small synchronous register bus. Writes are strobed and reads are combinational.

Top module: `wake_pin_ctrl`

## Requirements
- R1: After reset, every register reads 00h, `smi` is 0 and `pin_oe` and `pin_out` are 0.
- R2: Register address 0 holds the polarity bits in bits 2:0, with bit n for pin n. A 0 means active high and a 1 means active low. Bits 7:3 always read 0.
- R3: Register address 1 holds the interrupt-enable bits in bits 6:4, with pin n at bit 4+n, and the direction bits in bits 2:0, with 1 meaning output. Bits 7 and 3 always read 0.
- R4: `pin_oe` equals the direction bits. `pin_out` equals bits 2:0 of register address 2, whose bits 7:3 read 0.
- R5: A change of the synchronised, polarity-adjusted level is accepted only after 31 consecutive ticks at the new level. A shorter pulse, or time with `tick` low, accepts nothing. With `tick` held high, a pin change driven before edge 1 shows in status after edge 33 and not after edge 32.
- R6: An accepted change to the asserted level sets that pin's status bit in bits 2:0 of register address 3. A change to the deasserted level sets nothing. Status is set whatever the enable bit is.
- R7: A status bit stays set until a write to address 3 has a 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R8: A pin whose direction is output never sets its status bit. After it returns to input while already at its asserted level, it reports no event.
- R9: `smi` is 1 exactly when some pin has its status bit set, its enable bit set and its direction bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Debounce timebase strobe, one clock wide, nominally 1 MHz |
| reg_addr | input | 2 | Register select: 0 polarity, 1 enable/direction, 2 output data, 3 status |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_in | input | 3 | Raw pin levels, asynchronous |
| pin_oe | output | 3 | Per-pin output enable |
| pin_out | output | 3 | Per-pin output value |
| smi | output | 1 | Combined interrupt request |

## Verification
The main function is driven by a table of pin transitions, each under a different polarity, enable and direction setting:
- Rising and falling edges under both polarities show that an event follows the asserted level and not the edge direction.
- Mixed polarity across the three pins shows that each pin's polarity bit acts on that pin only.
- Patterns with the enable bits off or with pins set as outputs separate "status set" from "interrupt raised" and from "detection masked".

Directed cases then cover the following:
- A sub-window glitch.
- A window with `tick` held low.
- The exact edge-32 versus edge-33 acceptance point.
- An output-to-input switch while the pin sits at its asserted level.
- Clearing a single status bit by writing 1.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int NPIN = 3;
  localparam int REG_W = 8;
  localparam int EN_LSB = 4;

  typedef logic [NPIN-1:0] pinvec_t;

  localparam logic [1:0] ADDR_POL  = 2'd0;
  localparam logic [1:0] ADDR_CTL  = 2'd1;
  localparam logic [1:0] ADDR_DOUT = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;
endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/wpc_debounce.sv
module wpc_debounce #(
  parameter int TICKS = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  input  logic lvl,
  output logic db,
  output logic ev
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          db_q, db_d;

  always_comb begin
    cnt_d = cnt_q;
    db_d  = db_q;
    ev    = 1'b0;
    if (hold) begin
      db_d  = lvl;
      cnt_d = '0;
    end else if (lvl == db_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        db_d  = lvl;
        cnt_d = '0;
        ev    = lvl;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      db_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      db_q  <= db_d;
    end
  end

  assign db = db_q;
endmodule

// File: rtl/wpc_regs.sv
module wpc_regs
  import wpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  pinvec_t          ev,
  output logic [REG_W-1:0] rdata,
  output pinvec_t          pol,
  output pinvec_t          en,
  output pinvec_t          dir,
  output pinvec_t          dout,
  output pinvec_t          status
);
  pinvec_t pol_q, pol_d, en_q, en_d, dir_q, dir_d;
  pinvec_t dout_q, dout_d, stat_q, stat_d;
  pinvec_t clr;

  always_comb begin
    pol_d  = pol_q;
    en_d   = en_q;
    dir_d  = dir_q;
    dout_d = dout_q;
    clr    = '0;
    if (we) begin
      case (addr)
        ADDR_POL:  pol_d  = wdata[NPIN-1:0];
        ADDR_CTL: begin
          en_d  = wdata[EN_LSB +: NPIN];
          dir_d = wdata[NPIN-1:0];
        end
        ADDR_DOUT: dout_d = wdata[NPIN-1:0];
        default:   clr    = wdata[NPIN-1:0];
      endcase
    end
    stat_d = (stat_q & ~clr) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      en_q   <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      stat_q <= '0;
    end else begin
      pol_q  <= pol_d;
      en_q   <= en_d;
      dir_q  <= dir_d;
      dout_q <= dout_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_POL:  rdata[NPIN-1:0] = pol_q;
      ADDR_CTL: begin
        rdata[EN_LSB +: NPIN] = en_q;
        rdata[NPIN-1:0]       = dir_q;
      end
      ADDR_DOUT: rdata[NPIN-1:0] = dout_q;
      default:   rdata[NPIN-1:0] = stat_q;
    endcase
  end

  assign pol    = pol_q;
  assign en     = en_q;
  assign dir    = dir_q;
  assign dout   = dout_q;
  assign status = stat_q;
endmodule

// File: rtl/wake_pin_ctrl.sv
module wake_pin_ctrl
  import wpc_pkg::*;
#(
  parameter int DB_TICKS = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [2:0] pin_in,
  output logic [2:0] pin_oe,
  output logic [2:0] pin_out,
  output logic       smi
);
  logic [1:0] rst_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign core_rst_n = rst_q[1];

  pinvec_t pin_s, pol, en, dir, dout, status, ev, db;

  wpc_sync #(.W(NPIN)) sync_i (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .async_in (pin_in),
    .sync_out (pin_s)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    wpc_debounce #(.TICKS(DB_TICKS)) db_i (
      .clk   (clk),
      .rst_n (core_rst_n),
      .tick  (tick),
      .hold  (dir[g]),
      .lvl   (pin_s[g] ^ pol[g]),
      .db    (db[g]),
      .ev    (ev[g])
    );
  end

  wpc_regs regs_i (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .addr   (reg_addr),
    .we     (reg_we),
    .wdata  (reg_wdata),
    .ev     (ev),
    .rdata  (reg_rdata),
    .pol    (pol),
    .en     (en),
    .dir    (dir),
    .dout   (dout),
    .status (status)
  );

  assign pin_oe  = dir;
  assign pin_out = dout;
  assign smi     = |(status & en & ~dir);
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [2:0] clr_data,
  input logic [7:3] rdata_hi,
  input logic [2:0] pin_oe,
  input logic       smi,
  input logic [2:0] status,
  input logic [2:0] en,
  input logic [2:0] dir
);
  logic [2:0] clr_mask;
  assign clr_mask = (reg_we && reg_addr == 2'd3) ? clr_data : 3'b000;

  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(status) & ~status) & ~$past(clr_mask)) == 3'b000));

  // R8
  no_event_as_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((status & ~$past(status)) & $past(dir)) == 3'b000));

  // R4
  oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we && reg_addr == 2'd1) |-> $stable(pin_oe));

  // R9
  smi_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 3'b000) |-> !smi);

  // R2
  pol_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (rdata_hi == 5'b00000));

  // R3
  ctl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (!rdata_hi[7] && !rdata_hi[3]));
endmodule

bind wake_pin_ctrl wpc_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .clr_data (reg_wdata[2:0]),
  .rdata_hi (reg_rdata[7:3]),
  .pin_oe   (pin_oe),
  .smi      (smi),
  .status   (status),
  .en       (en),
  .dir      (dir)
);

// File: tb/wake_pin_ctrl_tb_top.sv
module wake_pin_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [2:0] pin_in = 3'b000;
  logic [2:0] pin_oe;
  logic [2:0] pin_out;
  logic       smi;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wake_pin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .smi(smi)
  );

  typedef struct packed {
    logic [2:0] pol;
    logic [7:0] ctl;
    logic [2:0] start_lvl;
    logic [2:0] end_lvl;
    logic [2:0] exp_stat;
    logic       exp_smi;
  } vec_t;

  // R6 / R9 / R8 / R2 pattern table
  localparam vec_t VECS [8] = '{
    '{3'b000, 8'h70, 3'b000, 3'b111, 3'b111, 1'b1},
    '{3'b000, 8'h70, 3'b111, 3'b000, 3'b000, 1'b0},
    '{3'b111, 8'h70, 3'b111, 3'b000, 3'b111, 1'b1},
    '{3'b000, 8'h00, 3'b000, 3'b111, 3'b111, 1'b0},
    '{3'b000, 8'h77, 3'b000, 3'b111, 3'b000, 1'b0},
    '{3'b010, 8'h50, 3'b000, 3'b101, 3'b101, 1'b1},
    '{3'b000, 8'h20, 3'b000, 3'b001, 3'b001, 1'b0},
    '{3'b000, 8'h71, 3'b000, 3'b111, 3'b110, 1'b1}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  // call only between edges
  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(5);

    // R1 reset state
    rd(2'd0, 8'h00, "R1 pol reg");
    rd(2'd1, 8'h00, "R1 ctl reg");
    rd(2'd2, 8'h00, "R1 dout reg");
    rd(2'd3, 8'h00, "R1 status reg");
    chk({7'b0, smi}, 8'h00, "R1 smi");
    chk({2'b0, pin_oe, pin_out}, 8'h00, "R1 pin_oe/pin_out");

    // R2 and R3 reserved bits
    wr(2'd0, 8'hFF); @(negedge clk); rd(2'd0, 8'h07, "R2 reserved read");
    wr(2'd1, 8'hFF); @(negedge clk); rd(2'd1, 8'h77, "R3 reserved read");
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h70);
    settle(80);
    wr(2'd3, 8'h07);

    // table walk: R6 R9 R8 R2
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, {5'b0, VECS[i].pol});
      wr(2'd1, VECS[i].ctl);
      @(negedge clk); pin_in = VECS[i].start_lvl;
      settle(80);
      wr(2'd3, 8'h07);
      @(negedge clk); pin_in = VECS[i].end_lvl;
      settle(80);
      rd(2'd3, {5'b0, VECS[i].exp_stat}, $sformatf("R6 vec%0d status", i));
      chk({7'b0, smi}, {7'b0, VECS[i].exp_smi}, $sformatf("R9 vec%0d smi", i));
    end

    // common base: active high inputs, all enabled, pins low
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h70);
    @(negedge clk); pin_in = 3'b000;
    settle(80);
    wr(2'd3, 8'h07);

    // R5 glitch shorter than window
    @(negedge clk); pin_in = 3'b001;
    settle(20);
    pin_in = 3'b000;
    settle(80);
    rd(2'd3, 8'h00, "R5 short glitch ignored");

    // R5 no ticks, no acceptance; ticks resume, accepted
    tick = 1'b0;
    pin_in = 3'b001;
    settle(80);
    rd(2'd3, 8'h00, "R5 tick low holds");
    tick = 1'b1;
    settle(80);
    rd(2'd3, 8'h01, "R5 tick resumes");
    pin_in = 3'b000;
    settle(80);
    wr(2'd3, 8'h07);

    // R5 exact acceptance edge
    @(negedge clk); pin_in = 3'b010;
    repeat (32) @(posedge clk);
    @(negedge clk);
    rd(2'd3, 8'h00, "R5 edge 32 not yet");
    @(posedge clk);
    @(negedge clk);
    rd(2'd3, 8'h02, "R5 edge 33 accepted");
    pin_in = 3'b000;
    settle(80);
    wr(2'd3, 8'h07);

    // R8 output then back to input while asserted
    wr(2'd1, 8'h71);
    @(negedge clk); pin_in = 3'b001;
    settle(80);
    rd(2'd3, 8'h00, "R8 output masked");
    wr(2'd1, 8'h70);
    settle(80);
    rd(2'd3, 8'h00, "R8 no event on return to input");
    chk({7'b0, smi}, 8'h00, "R8 smi");
    pin_in = 3'b000;
    settle(80);
    wr(2'd3, 8'h07);

    // R7 write-one-to-clear
    @(negedge clk); pin_in = 3'b111;
    settle(80);
    rd(2'd3, 8'h07, "R7 all set");
    wr(2'd3, 8'h02); @(negedge clk);
    rd(2'd3, 8'h05, "R7 clear one bit");
    wr(2'd3, 8'h00); @(negedge clk);
    rd(2'd3, 8'h05, "R7 zero write keeps");

    // R9 gating by enable and direction
    chk({7'b0, smi}, 8'h01, "R9 enabled smi");
    wr(2'd1, 8'h00); @(negedge clk);
    chk({7'b0, smi}, 8'h00, "R9 disabled smi");
    rd(2'd3, 8'h05, "R9 status kept");
    wr(2'd1, 8'h50); @(negedge clk);
    chk({7'b0, smi}, 8'h01, "R9 partial enable smi");
    wr(2'd1, 8'h55); @(negedge clk);
    chk({7'b0, smi}, 8'h00, "R9 outputs gate smi");

    // R4 pin drive
    wr(2'd2, 8'hFD); @(negedge clk);
    rd(2'd2, 8'h05, "R4 dout read");
    wr(2'd1, 8'h07); @(negedge clk);
    chk({5'b0, pin_oe}, 8'h07, "R4 pin_oe");
    chk({5'b0, pin_out}, 8'h05, "R4 pin_out");

    summary();
    $finish;
  end
endmodule